// File: doc/BRIEF.md
# DRAM Bank State Tracker and Command Generator

This block sits between the address stage and the command scheduler of a DRAM controller. It keeps one small state machine per internal bank. Each machine records whether the bank has a row open and, if so, which row. Every read or write request carries a bank, a row and a column. The block looks up the target bank, decides whether the request is a row hit, a bank miss (bank closed) or a row conflict (a different row open), and then hands the scheduler the command sequence that the case needs.

A hit needs only the column command. A miss needs an ACTIVATE and then the column command. A conflict needs a PRECHARGE, then an ACTIVATE for the new row, then the column command. Commands leave through a valid/ready handshake. A bank machine moves only when a command for its bank is accepted. Only one request is in flight at a time: the request side is held off until the last command of the current sequence has been taken. DRAM timing, refresh and initialization are left to other blocks.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank is closed, `reqReady` is 1 and `cmdValid` is 0.
- R2: A request to a closed bank is a miss (`cmdClass` = 1). It produces exactly ACTIVATE and then the column command.
- R3: A request to a bank whose open row equals the request row is a hit (`cmdClass` = 0). It produces only the column command.
- R4: A request to a bank open on a different row is a conflict (`cmdClass` = 2). It produces PRECHARGE, then ACTIVATE, then the column command.
- R5: Banks are independent. A command to one bank never changes the open or closed state, or the open row, of any other bank.
- R6: `reqReady` is 0 from the cycle after a request is accepted until the cycle after its last command is accepted. A request presented while `reqReady` is 0 is not taken and produces no command.
- R7: While `cmdValid` is 1 and `cmdReady` is 0, the command and all of its fields hold unchanged in the next cycle.
- R8: `cmdOp` encodes ACTIVATE=1, READ=2, WRITE=3 and PRECHARGE=4. It is never 0 while `cmdValid` is 1. The column command is WRITE when `reqWrite` was 1 and READ otherwise. Every command of a sequence carries the request's bank, row, column and class.
- R9: After a request's column command has been accepted, its bank is open on the request row. The next request is classified against this updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | 3 | Target bank |
| reqRow | input | 14 | Target row |
| reqCol | input | 10 | Target column |
| cmdValid | output | 1 | Command present to the scheduler |
| cmdReady | input | 1 | Scheduler takes the command |
| cmdOp | output | 3 | Command code: 1 ACT, 2 READ, 3 WRITE, 4 PRE |
| cmdBank | output | 3 | Command bank |
| cmdRow | output | 14 | Row of the request |
| cmdCol | output | 10 | Column of the request |
| cmdClass | output | 2 | Request class: 0 hit, 1 miss, 2 conflict |

## Verification
The stimulus keeps row numbers in a small range, so that hits, misses and conflicts all occur often on the same bank. A design that compared rows wrongly would then issue an extra ACTIVATE, or would skip the PRECHARGE. The scheduler side stalls at random. This catches a design that updates a bank on presentation rather than on acceptance, or that lets command fields drift while a command is held. Junk requests are driven during every busy window, which exposes a design that takes a second request early. Directed sequences touch a second bank between accesses to a first bank, which exposes bank state that leaks across bank boundaries.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } cmdOpT;

  typedef enum logic [1:0] {
    CLS_HIT      = 2'd0,
    CLS_MISS     = 2'd1,
    CLS_CONFLICT = 2'd2
  } reqClassT;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_ACTIVATING,
    BK_ACTIVE,
    BK_PRECHARGING
  } bankStT;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_ACT,
    PH_COL
  } phaseT;

  typedef struct packed {
    logic  capture;
    logic  firePre;
    logic  fireAct;
    logic  fireCol;
    phaseT phase;
  } ctlStrobeT;

endpackage

// File: rtl/bank_trk_bank.sv
module bank_trk_bank
  import bank_trk_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             preFire,
  input  logic             actFire,
  input  logic             colFire,
  input  logic [ROW_W-1:0] actRow,
  output bankStT           state,
  output logic [ROW_W-1:0] openRow
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= BK_IDLE;
      openRow <= '0;
    end else if (preFire) begin
      state <= BK_PRECHARGING;
    end else if (actFire) begin
      state   <= BK_ACTIVATING;
      openRow <= actRow;
    end else if (colFire) begin
      state <= BK_ACTIVE;
    end
  end

endmodule

// File: rtl/bank_trk_ctrl.sv
module bank_trk_ctrl
  import bank_trk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      cmdReady,
  input  reqClassT  lookupClass,
  output logic      reqReady,
  output logic      cmdValid,
  output ctlStrobeT strobe
);

  phaseT phase, phaseNext;
  logic  accept, fire;

  assign reqReady = (phase == PH_IDLE);
  assign cmdValid = (phase != PH_IDLE);
  assign accept   = reqValid && reqReady;
  assign fire     = cmdValid && cmdReady;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (accept) begin
        unique case (lookupClass)
          CLS_HIT:      phaseNext = PH_COL;
          CLS_MISS:     phaseNext = PH_ACT;
          CLS_CONFLICT: phaseNext = PH_PRE;
          default:      phaseNext = PH_ACT;
        endcase
      end
      PH_PRE: if (fire) phaseNext = PH_ACT;
      PH_ACT: if (fire) phaseNext = PH_COL;
      PH_COL: if (fire) phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobe.capture = accept;
    strobe.firePre = fire && (phase == PH_PRE);
    strobe.fireAct = fire && (phase == PH_ACT);
    strobe.fireCol = fire && (phase == PH_COL);
    strobe.phase   = phase;
  end

endmodule

// File: rtl/bank_trk_datapath.sv
module bank_trk_datapath
  import bank_trk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobe,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output reqClassT          lookupClass,
  output cmdOpT             cmdOp,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output reqClassT          cmdClass
);

  logic              curWrite;
  logic [BANK_W-1:0] curBank;
  logic [ROW_W-1:0]  curRow;
  logic [COL_W-1:0]  curCol;
  reqClassT          curClass;

  bankStT           bankSt  [NUM_BANKS];
  logic [ROW_W-1:0] openRows[NUM_BANKS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curBank  <= '0;
      curRow   <= '0;
      curCol   <= '0;
      curClass <= CLS_MISS;
    end else if (strobe.capture) begin
      curWrite <= reqWrite;
      curBank  <= reqBank;
      curRow   <= reqRow;
      curCol   <= reqCol;
      curClass <= lookupClass;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic hitMe;
    assign hitMe = (curBank == BANK_W'(g));
    bank_trk_bank #(.ROW_W(ROW_W)) bank_i (
      .clk     (clk),
      .rstN    (rstN),
      .preFire (strobe.firePre && hitMe),
      .actFire (strobe.fireAct && hitMe),
      .colFire (strobe.fireCol && hitMe),
      .actRow  (curRow),
      .state   (bankSt[g]),
      .openRow (openRows[g])
    );
  end

  always_comb begin
    if (bankSt[reqBank] != BK_ACTIVE)      lookupClass = CLS_MISS;
    else if (openRows[reqBank] == reqRow)  lookupClass = CLS_HIT;
    else                                   lookupClass = CLS_CONFLICT;
  end

  always_comb begin
    unique case (strobe.phase)
      PH_PRE:  cmdOp = OP_PRE;
      PH_ACT:  cmdOp = OP_ACT;
      PH_COL:  cmdOp = curWrite ? OP_WR : OP_RD;
      default: cmdOp = OP_NOP;
    endcase
  end

  assign cmdBank  = curBank;
  assign cmdRow   = curRow;
  assign cmdCol   = curCol;
  assign cmdClass = curClass;

endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import bank_trk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [2:0]        cmdOp,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic [1:0]        cmdClass
);

  ctlStrobeT strobe;
  reqClassT  lookupClass;
  cmdOpT     dpOp;
  reqClassT  dpClass;

  bank_trk_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .cmdReady    (cmdReady),
    .lookupClass (lookupClass),
    .reqReady    (reqReady),
    .cmdValid    (cmdValid),
    .strobe      (strobe)
  );

  bank_trk_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqWrite    (reqWrite),
    .reqBank     (reqBank),
    .reqRow      (reqRow),
    .reqCol      (reqCol),
    .lookupClass (lookupClass),
    .cmdOp       (dpOp),
    .cmdBank     (cmdBank),
    .cmdRow      (cmdRow),
    .cmdCol      (cmdCol),
    .cmdClass    (dpClass)
  );

  assign cmdOp    = dpOp;
  assign cmdClass = dpClass;

endmodule

// File: rtl/bank_trk_chk.sv
module bank_trk_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [2:0]        cmdOp,
  input logic [BANK_W-1:0] cmdBank,
  input logic [ROW_W-1:0]  cmdRow,
  input logic [COL_W-1:0]  cmdCol,
  input logic [1:0]        cmdClass
);

  // R7
  held_cmd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdOp) && $stable(cmdBank)
      && $stable(cmdRow) && $stable(cmdCol) && $stable(cmdClass)));

  // R8
  valid_op_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdOp >= 3'd1 && cmdOp <= 3'd4));

  // R4
  pre_then_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp == 3'd4) |=>
      (cmdValid && cmdOp == 3'd1 && $stable(cmdBank)));

  // R2
  act_then_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp == 3'd1) |=>
      (cmdValid && (cmdOp == 3'd2 || cmdOp == 3'd3) && $stable(cmdBank)));

  // R3
  hit_column_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdClass == 2'd0) |-> (cmdOp == 3'd2 || cmdOp == 3'd3));

  // R6
  accept_starts_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (cmdValid && !reqReady));

  // R6
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !reqReady);

endmodule

bind dram_bank_tracker bank_trk_chk #(
  .BANK_W (BANK_W),
  .ROW_W  (ROW_W),
  .COL_W  (COL_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdOp    (cmdOp),
  .cmdBank  (cmdBank),
  .cmdRow   (cmdRow),
  .cmdCol   (cmdCol),
  .cmdClass (cmdClass)
);

// File: tb/dram_bank_tracker_tb_top.sv
module dram_bank_tracker_tb_top;

  localparam int NB = 8;
  localparam int RW = 14;
  localparam int CW = 10;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [BW-1:0] reqBank = '0;
  logic [RW-1:0] reqRow = '0;
  logic [CW-1:0] reqCol = '0;
  logic          cmdValid;
  logic          cmdReady = 1'b0;
  logic [2:0]    cmdOp;
  logic [BW-1:0] cmdBank;
  logic [RW-1:0] cmdRow;
  logic [CW-1:0] cmdCol;
  logic [1:0]    cmdClass;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit          mOpen[NB];
  bit [RW-1:0] mRow [NB];

  always #5 clk = ~clk;

  dram_bank_tracker dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol), .cmdClass(cmdClass)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(logic [2:0] op, logic [BW-1:0] b,
                                       logic [RW-1:0] r, logic [CW-1:0] c, logic [1:0] k);
    return {op, b, r, c, k};
  endfunction

  function automatic logic [1:0] expClass(logic [BW-1:0] b, logic [RW-1:0] r);
    if (!mOpen[b]) return 2'd1;
    if (mRow[b] == r) return 2'd0;
    return 2'd2;
  endfunction

  task automatic doReq(bit w, logic [BW-1:0] b, logic [RW-1:0] r, logic [CW-1:0] c,
                       string extra);
    logic [1:0]  cls;
    logic [2:0]  ops[3];
    int          n;
    int          k;
    int          guard;
    bit          held;
    logic [31:0] saved;
    string       tag;
    cls = expClass(b, r);
    if (cls == 2'd0) begin
      n = 1; ops[0] = w ? 3'd3 : 3'd2; tag = "R3";
    end else if (cls == 2'd1) begin
      n = 2; ops[0] = 3'd1; ops[1] = w ? 3'd3 : 3'd2; tag = "R2";
    end else begin
      n = 3; ops[0] = 3'd4; ops[1] = 3'd1; ops[2] = w ? 3'd3 : 3'd2; tag = "R4";
    end
    tag = {extra, tag};
    @(negedge clk);
    check(reqReady == 1'b1 && cmdValid == 1'b0, "R6", "idle before request",
          {reqReady, cmdValid}, 2'b10);
    reqValid = 1'b1; reqWrite = w; reqBank = b; reqRow = r; reqCol = c;
    @(negedge clk);
    // junk request while busy: must be ignored (R6)
    reqWrite = 1'($urandom); reqBank = BW'($urandom); reqRow = RW'($urandom);
    reqCol = CW'($urandom);
    k = 0; guard = 0; held = 0; saved = '0;
    while (k < n && guard < 200) begin
      guard++;
      check(cmdValid == 1'b1 && reqReady == 1'b0, "R6", "busy handshake",
            {cmdValid, reqReady}, 2'b10);
      if (held)
        check(pack(cmdOp, cmdBank, cmdRow, cmdCol, cmdClass) == saved, "R7",
              "held command", pack(cmdOp, cmdBank, cmdRow, cmdCol, cmdClass), saved);
      cmdReady = (($urandom % 4) != 0);
      if (cmdReady) begin
        check(pack(cmdOp, cmdBank, cmdRow, cmdCol, cmdClass) == pack(ops[k], b, r, c, cls),
              tag, "command", pack(cmdOp, cmdBank, cmdRow, cmdCol, cmdClass),
              pack(ops[k], b, r, c, cls));
        check(cmdOp >= 3'd1 && cmdOp <= 3'd4, "R8", "op code", cmdOp, ops[k]);
        k++;
        held = 0;
        if (k == n) reqValid = 1'b0;
      end else begin
        held = 1;
        saved = pack(cmdOp, cmdBank, cmdRow, cmdCol, cmdClass);
      end
      @(negedge clk);
    end
    if (guard >= 200) check(1'b0, tag, "sequence watchdog", k, n);
    reqValid = 1'b0;
    cmdReady = 1'b0;
    check(cmdValid == 1'b0 && reqReady == 1'b1, "R6", "junk not taken",
          {cmdValid, reqReady}, 2'b01);
    mOpen[b] = 1'b1;
    mRow[b]  = r;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NB; i++) begin mOpen[i] = 0; mRow[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1 && cmdValid == 1'b0, "R1", "reset outputs",
          {reqReady, cmdValid}, 2'b10);

    // Directed corner cases
    doReq(1'b0, 3'd3, 14'd5, 10'd7, "R1 ");      // closed bank: miss
    doReq(1'b1, 3'd3, 14'd5, 10'd8, "R9 ");      // back-to-back same row: hit
    doReq(1'b0, 3'd3, 14'd9, 10'd1, "R9 ");      // other row: conflict
    doReq(1'b0, 3'd4, 14'd9, 10'd2, "R5 ");      // other bank still closed: miss
    doReq(1'b1, 3'd3, 14'd9, 10'd3, "R5 ");      // bank 3 unaffected: hit
    doReq(1'b1, 3'd4, 14'h3fff, 10'h3ff, "R5 "); // extreme row conflict on bank 4
    doReq(1'b0, 3'd7, 14'd0, 10'd0, "R8 ");      // last bank, read

    // Constrained random traffic, small row range to force all classes
    for (int i = 0; i < 400; i++) begin
      doReq(1'($urandom), BW'($urandom % NB), RW'($urandom % 4), CW'($urandom), "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule